// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block is a timer with five channels, each built around a counter that counts down toward zero. Four channels compare their counter against a compare value and drive a PWM pin. The fifth channel has no compare value and no pin, so it serves as a plain countdown timer. Software programs each channel through double-buffered count and compare registers. The buffers reach the live counter only through a manual-update control bit, or at the end of a period when auto-reload is enabled.

Each channel advances on its own tick. Two 8-bit prescalers produce the base ticks: one is shared by channels 0 and 1, and the other by channels 2, 3 and 4. Each channel then divides its group's base tick by a power of two that it selects itself. Registers are written and read through a simple word-addressed port. A write takes effect at the clock edge where the write strobe is high. Read data is returned combinationally, with no wait states.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register and every live counter reads zero, all four PWM pins are low and no expiry pulse is present.
- R2: Word addresses are fixed as follows: 0 holds the prescalers, 1 holds the divider selects and 2 holds the control register. For channel c, address 3+3c is the count buffer, 4+3c is the compare buffer (channels 0 to 3 only) and 5+3c is the read-only live counter. Channel 4 therefore uses 15 for its count buffer and 17 for its live counter. Writable registers read back exactly what was last written. Writes to a live-counter address or to address 16 change nothing.
- R3: While a channel's update bit is set, its live counter is held at the count buffer value and its compare register is loaded from the compare buffer.
- R4: A started channel with its update bit clear decrements by one on each of its ticks. With its start bit clear, it holds its value.
- R5: The tick period is (P+1)·2^n clocks. P is bits [7:0] of address 0 for channels 0 and 1, and bits [15:8] of address 0 for channels 2 to 4. n is the 4-bit field at bits [4c+3:4c] of address 1.
- R6: With auto-reload set, a counter that reaches zero reloads from the count buffer on its next tick. This gives a period of count+1 ticks. A one-clock expiry pulse is issued each time the counter steps from 1 to 0.
- R7: With auto-reload clear, the counter stops at zero and issues a single expiry pulse.
- R8: A channel's PWM level before inversion is high while the channel is started and its counter is at most its compare value, and low otherwise. This gives compare+1 high ticks per period.
- R9: Control bit positions for channels 0 to 3 start at bit base b = 0, 8, 12, 16. Within each group, b is start, b+1 is update, b+2 inverts the pin and b+3 is auto-reload.
- R10: Channel 4 uses control bit 20 for start, bit 21 for update and bit 22 for auto-reload. Loaded with all ones, it counts down as a free timer.
- R11: Buffer writes during a running period take effect only at the next reload. A write that lands on the reload edge itself is taken at the reload after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_o | output | 4 | PWM pins of channels 0 to 3 |
| expire_o | output | 5 | One-clock expiry pulse per channel |

## Verification
An auto-reload and a software write to the same count buffer can fall on the same clock edge. The bench provokes this on a running channel. It watches for the expiry pulse and then drives a new count so that the write lands on the very next edge, which is the reload edge. It then measures the two periods that follow: the first must still use the old count and only the second may use the new one.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int NCH       = 5;
   localparam int NPWM      = 4;
   localparam int A_CFG0    = 0;
   localparam int A_CFG1    = 1;
   localparam int A_CTRL    = 2;
   localparam int A_CH_BASE = 3;
   localparam int A_STRIDE  = 3;
   localparam int CTRL_W    = 23;

   // base bit of a channel's control group
   function automatic int ctl_base(input int c);
      return (c == 0) ? 0 : (c == NPWM) ? 20 : 4 + 4 * c;
   endfunction

   function automatic int reload_pos(input int c);
      return (c == NPWM) ? 22 : ctl_base(c) + 3;
   endfunction

   // prescaler group of a channel
   function automatic int grp_of(input int c);
      return (c < 2) ? 0 : 1;
   endfunction
endpackage

// File: rtl/pwmt_tick_gen.sv
module pwmt_tick_gen #(
   parameter int PRE_W = 8,
   parameter int DIV_W = 4,
   localparam int DCNT_W = (1 << DIV_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRE_W-1:0]  pre_val,
   output logic              pre_tick,
   output logic [DCNT_W-1:0] div_cnt
);
   logic [PRE_W-1:0] pc_q;

   assign pre_tick = (pc_q >= pre_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         div_cnt <= '0;
      end else if (pre_tick) begin
         pc_q    <= '0;
         div_cnt <= div_cnt + 1'b1;
      end else begin
         pc_q    <= pc_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan #(
   parameter int CNT_W   = 16,
   parameter int DIV_W   = 4,
   parameter bit HAS_OUT = 1'b1,
   localparam int DCNT_W = (1 << DIV_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_tick,
   input  logic [DCNT_W-1:0] div_cnt,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic              run,
   input  logic              upd,
   input  logic              inv,
   input  logic              rel,
   input  logic [CNT_W-1:0]  cnt_buf,
   input  logic [CNT_W-1:0]  cmp_buf,
   output logic              ch_tick,
   output logic [CNT_W-1:0]  cnt,
   output logic              expire,
   output logic              pwm
);
   logic [DCNT_W-1:0] mask;
   logic              step;
   logic              at_zero;
   logic              load_now;

   assign mask     = ~({DCNT_W{1'b1}} << div_sel);
   assign ch_tick  = pre_tick && ((div_cnt & mask) == mask);
   assign step     = run && ch_tick;
   assign at_zero  = (cnt == '0);
   assign load_now = upd || (step && at_zero && rel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         expire <= 1'b0;
      end else begin
         expire <= !upd && step && (cnt == CNT_W'(1));
         if (load_now)
            cnt <= cnt_buf;
         else if (step && !at_zero)
            cnt <= cnt - 1'b1;
      end
   end

   generate
      if (HAS_OUT) begin : g_out
         logic [CNT_W-1:0] cmp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cmp_q <= '0;
            else if (load_now) cmp_q <= cmp_buf;
         end
         assign pwm = (run && (cnt <= cmp_q)) ^ inv;
      end else begin : g_no_out
         logic unused_cmp;
         assign unused_cmp = ^{cmp_buf, inv};
         assign pwm = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 8,
   parameter int DIV_W  = 4,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [3:0]        pwm_o,
   output logic [4:0]        expire_o
);
   import pwmt_pkg::*;

   localparam int DCNT_W  = (1 << DIV_W) - 1;
   localparam int LAST_A  = A_CH_BASE + A_STRIDE * (NCH - 1) + 2;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (DATA_W < CTRL_W || DATA_W < 2 * PRE_W || DATA_W < NCH * DIV_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
      if ((1 << ADDR_W) <= LAST_A) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("DIV_W must be 1 to 4");
      end
   endgenerate

   logic [2*PRE_W-1:0]            cfg0_q;
   logic [NCH*DIV_W-1:0]          cfg1_q;
   logic [CTRL_W-1:0]             ctrl_q;
   logic [NCH-1:0][CNT_W-1:0]     cnt_buf;
   logic [NPWM-1:0][CNT_W-1:0]    cmp_buf;
   logic [NCH-1:0][CNT_W-1:0]     cnt_live;
   logic [NCH-1:0]                run, upd, inv, rel, ch_tick, pwm_raw;
   logic [1:0]                    pre_tick;
   logic [1:0][DCNT_W-1:0]        div_cnt;
   logic                          unused_bits;

   assign unused_bits = ^{bus_wdata[DATA_W-1:CTRL_W], pwm_raw[NCH-1]};

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg0_q  <= '0;
         cfg1_q  <= '0;
         ctrl_q  <= '0;
         cnt_buf <= '0;
         cmp_buf <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_CFG0)) cfg0_q <= bus_wdata[2*PRE_W-1:0];
         if (bus_addr == ADDR_W'(A_CFG1)) cfg1_q <= bus_wdata[NCH*DIV_W-1:0];
         if (bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
         for (int c = 0; c < NCH; c++)
            if (bus_addr == ADDR_W'(A_CH_BASE + A_STRIDE * c))
               cnt_buf[c] <= bus_wdata[CNT_W-1:0];
         for (int c = 0; c < NPWM; c++)
            if (bus_addr == ADDR_W'(A_CH_BASE + A_STRIDE * c + 1))
               cmp_buf[c] <= bus_wdata[CNT_W-1:0];
      end
   end

   // register reads
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CFG0)) bus_rdata[2*PRE_W-1:0]   = cfg0_q;
      if (bus_addr == ADDR_W'(A_CFG1)) bus_rdata[NCH*DIV_W-1:0] = cfg1_q;
      if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata[CTRL_W-1:0]    = ctrl_q;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == ADDR_W'(A_CH_BASE + A_STRIDE * c))
            bus_rdata[CNT_W-1:0] = cnt_buf[c];
         if (bus_addr == ADDR_W'(A_CH_BASE + A_STRIDE * c + 2))
            bus_rdata[CNT_W-1:0] = cnt_live[c];
      end
      for (int c = 0; c < NPWM; c++)
         if (bus_addr == ADDR_W'(A_CH_BASE + A_STRIDE * c + 1))
            bus_rdata[CNT_W-1:0] = cmp_buf[c];
   end

   genvar g, c;
   generate
      for (g = 0; g < 2; g++) begin : g_grp
         pwmt_tick_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_val  (cfg0_q[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick[g]),
            .div_cnt  (div_cnt[g])
         );
      end

      for (c = 0; c < NCH; c++) begin : g_ch
         localparam int GRP = grp_of(c);
         localparam int CI  = (c < NPWM) ? c : 0;
         assign run[c] = ctrl_q[ctl_base(c)];
         assign upd[c] = ctrl_q[ctl_base(c) + 1];
         assign rel[c] = ctrl_q[reload_pos(c)];
         if (c < NPWM) begin : g_inv
            assign inv[c] = ctrl_q[ctl_base(c) + 2];
         end else begin : g_noinv
            assign inv[c] = 1'b0;
         end

         pwmt_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W), .HAS_OUT(c < NPWM)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_tick (pre_tick[GRP]),
            .div_cnt  (div_cnt[GRP]),
            .div_sel  (cfg1_q[c*DIV_W +: DIV_W]),
            .run      (run[c]),
            .upd      (upd[c]),
            .inv      (inv[c]),
            .rel      (rel[c]),
            .cnt_buf  (cnt_buf[c]),
            .cmp_buf  (cmp_buf[CI]),
            .ch_tick  (ch_tick[c]),
            .cnt      (cnt_live[c]),
            .expire   (expire_o[c]),
            .pwm      (pwm_raw[c])
         );
      end
   endgenerate

   assign pwm_o = pwm_raw[NPWM-1:0];
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
   parameter int NCH   = 5,
   parameter int CNT_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCH-1:0]        upd,
   input logic [NCH-1:0]        run,
   input logic [NCH-1:0]        rel,
   input logic [NCH-1:0]        tick,
   input logic [NCH-1:0]        expire,
   input logic [NCH-1:0][CNT_W-1:0] cnt,
   input logic [NCH-1:0][CNT_W-1:0] cnt_buf
);
   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_chk
         assert_update_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            upd[c] |=> cnt[c] == $past(cnt_buf[c]));

         assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run[c] && !upd[c] && tick[c] && cnt[c] != '0) |=> cnt[c] == $past(cnt[c]) - 1'b1);

         assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[c] && !upd[c]) |=> $stable(cnt[c]));

         assert_expiry_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |-> cnt[c] == '0);

         assert_expiry_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] |=> !expire[c]);

         assert_oneshot_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[c] == '0 && !rel[c] && !upd[c]) |=> cnt[c] == '0);
      end
   endgenerate
endmodule

bind pwm_timer pwmt_checker #(.NCH(pwmt_pkg::NCH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .upd     (upd),
   .run     (run),
   .rel     (rel),
   .tick    (ch_tick),
   .expire  (expire_o),
   .cnt     (cnt_live),
   .cnt_buf (cnt_buf)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire  [3:0]  pwm_o;
   wire  [4:0]  expire_o;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int exp_n[5]    = '{default:0};
   int last_t[5]   = '{default:0};
   int last_int[5] = '{default:0};
   bit done = 1'b0;

   pwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o), .expire_o(expire_o)
   );

   always #2 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      for (int c = 0; c < 5; c++)
         if (expire_o[c]) begin
            exp_n[c]++;
            last_int[c] = cyc - last_t[c];
            last_t[c]   = cyc;
         end
   end

   task automatic chk_eq(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input longint exp);
      logic [31:0] d;
      rd(a, d);
      chk_eq(req, d, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      for (int a = 0; a < 18; a++) rd_chk("R1 reg", 5'(a), 0);
      chk_eq("R1 pwm", pwm_o, 0);
      chk_eq("R1 expire", expire_o, 0);
   endtask

   task automatic t_regmap();
      wr(0, 32'hA5C3);  wr(1, 32'h54321); wr(2, 32'hF0);
      for (int c = 0; c < 5; c++) wr(5'(3 + 3 * c), 32'h100 + c);
      for (int c = 0; c < 4; c++) wr(5'(4 + 3 * c), 32'h200 + c);
      rd_chk("R2 cfg0", 0, 32'hA5C3);
      rd_chk("R2 cfg1", 1, 32'h54321);
      rd_chk("R2 ctrl", 2, 32'hF0);
      for (int c = 0; c < 5; c++) rd_chk("R2 count buf", 5'(3 + 3 * c), 32'h100 + c);
      for (int c = 0; c < 4; c++) rd_chk("R2 compare buf", 5'(4 + 3 * c), 32'h200 + c);
      wr(5, 32'hBEEF); wr(16, 32'h7777);
      rd_chk("R2 live ro", 5, 0);
      rd_chk("R2 hole", 16, 0);
      rd_chk("R2 neighbour cnt", 3, 32'h100);
      rd_chk("R2 neighbour cmp", 4, 32'h200);
      rd_chk("R2 ch4 buf", 15, 32'h104);
   endtask

   task automatic t_update_count();
      wr(2, 0); wr(0, 0); wr(1, 0);
      wr(3, 9); wr(4, 3);
      wr(2, 32'h2);
      idle(1);
      rd_chk("R3 loaded", 5, 9);
      idle(3);
      rd_chk("R3 held", 5, 9);
      wr(2, 32'h1);
      rd_chk("R4 first", 5, 9);
      idle(1);
      rd_chk("R4 dec", 5, 8);
      wr(2, 0);
      rd_chk("R4 stop", 5, 6);
      idle(5);
      rd_chk("R4 stop hold", 5, 6);
      exp_n[0] = 0;
      wr(2, 32'h1);
      idle(20);
      chk_eq("R7 one pulse", exp_n[0], 1);
      rd_chk("R7 at zero", 5, 0);
   endtask

   task automatic t_duty();
      int hi, e0;
      wr(2, 0); wr(6, 4); wr(7, 1);
      wr(2, 32'h200); wr(2, 32'h900);
      idle(10);
      hi = 0; e0 = exp_n[1];
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (pwm_o[1]) hi++;
      end
      chk_eq("R8 high cycles", hi, 20);
      chk_eq("R6 pulses", exp_n[1] - e0, 10);
      chk_eq("R6 period", last_int[1], 5);
      wr(2, 32'hD00);
      idle(10);
      hi = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (pwm_o[1]) hi++;
      end
      chk_eq("R9 inverted high", hi, 30);
   endtask

   task automatic t_prescale();
      wr(2, 0);
      wr(0, 32'h0201); wr(1, 32'h201);
      wr(3, 2); wr(9, 3);
      wr(2, 32'h2002); wr(2, 32'h9009);
      idle(300);
      chk_eq("R5 ch0 period", last_int[0], 12);
      chk_eq("R5 ch2 period", last_int[2], 48);
   endtask

   task automatic t_timer();
      wr(2, 0); wr(0, 0); wr(1, 0);
      wr(15, 32'hFFFF);
      wr(2, 32'h200000); wr(2, 32'h100000);
      rd_chk("R10 all ones", 17, 32'hFFFF);
      idle(10);
      rd_chk("R10 counting", 17, 32'hFFF5);
      wr(15, 2);
      wr(2, 32'h200000); wr(2, 32'h500000);
      idle(40);
      chk_eq("R10 reload period", last_int[4], 3);
   endtask

   task automatic t_collision();
      int d1, d2;
      wr(2, 0); wr(3, 5);
      wr(2, 32'h2); wr(2, 32'h9);
      idle(20);
      chk_eq("R6 ch0 period", last_int[0], 6);
      @(negedge clk);
      while (!expire_o[0]) @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3; bus_wdata = 9;
      @(negedge clk);
      bus_wr = 1'b0;
      d1 = 1;
      while (!expire_o[0]) begin @(negedge clk); d1++; end
      @(negedge clk);
      d2 = 1;
      while (!expire_o[0]) begin @(negedge clk); d2++; end
      chk_eq("R11 old count at collision", d1, 6);
      chk_eq("R11 new count next", d2, 10);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_regmap();
      t_update_count();
      t_duty();
      t_prescale();
      t_timer();
      t_collision();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule